// File: doc/BRIEF.md
# Stereo Soft-Mute Gain Ramp

This block sits on the DAC path of a stereo 24-bit sample stream. It takes a gain from a 32-step table shaped like a raised cosine and multiplies every sample by it. When a mute is requested, the gain slides from unity down to zero. When the request is withdrawn, the gain climbs back along the same curve in the opposite direction. Each table step is applied to four consecutive samples, so a complete fade in either direction takes 128 samples. At 44.1 kHz that is roughly 3 ms.

A mute request comes from an external pin or from any of a small group of register bits. If the pin is holding the mute and the fade has reached silence, the block raises a power-down request for the converter. A separate hard-mute input has priority over the ramp. The receiver raises it on loss of lock or on a line-coding violation. It silences the next emitted sample at once. The ramp keeps tracking the request in the background, so when the hard mute drops, the output resumes at whatever gain the ramp has reached.

Top module: `cos_fade_mute`

## Requirements
- R1: The effective mute request is the OR of `mute_pin_i` and every bit of `mute_reg_i`. A register bit alone fades the output exactly as the pin does.
- R2: Gains are unsigned 14-bit fractions in which 8192 means 1.0. For table entry k of 32, the gain is (8192·(29791 − 93k² + 2k³) + 14895) / 29791, using integer division. Entry 0 is 8192 and entry 31 is 0.
- R3: The ramp keeps a position from 0 to 127, and the gain used is entry position/4. On each strobe with the request high, the position advances by one, stopping at 127. Starting from unity, strobes 1 to 124 carry non-zero gain, and strobe 125 onward is silent.
- R4: On each strobe with the request low, the position falls by one, stopping at 0. The table is therefore replayed in reverse, and full level returns after 128 strobes.
- R5: A change of request in the middle of a ramp reverses it from the current position. The ramp does not restart.
- R6: Each output equals (sample·gain + 4096) arithmetically shifted right by 13. It appears in the cycle after the strobe and is held unchanged while no strobe arrives. The gain used is the one before that strobe's position update.
- R7: A strobe with `hard_mute_i` high emits zero on both channels whatever the ramp gain, and leaves the ramp position unaffected.
- R8: `muted_o` is high exactly when the most recently emitted sample pair had zero gain, either because the ramp sat at a zero entry or because hard mute was applied.
- R9: `dac_pd_o` is high exactly when the most recent strobe used a zero ramp gain while `mute_pin_i` was high.
- R10: Reset is synchronous and active high. It clears the outputs and flags to 0 and returns the ramp to unity gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| smp_stb_i | input | 1 | One-cycle strobe marking a new sample pair |
| smp_l_i | input | 24 | Left input sample, two's complement |
| smp_r_i | input | 24 | Right input sample, two's complement |
| mute_pin_i | input | 1 | Mute request from the external pin |
| mute_reg_i | input | NREG (2) | Mute request bits from control registers |
| hard_mute_i | input | 1 | Immediate silence request from the receiver |
| smp_l_o | output | 24 | Scaled left sample |
| smp_r_o | output | 24 | Scaled right sample |
| muted_o | output | 1 | Last emitted pair had zero gain |
| dac_pd_o | output | 1 | Converter power-down request |

## Verification
The hardest condition to reach is a reversal at a position that is not a multiple of four. That means changing the request after a chosen number of strobes, partway through a held entry, and checking that the climb starts from that same partially used entry. The stimulus counts strobes into a fade, flips the request at odd offsets, and inserts strobe-free cycles between samples. It also applies hard mute while the pin-driven fade sits at silence, and again while the gain is mid-curve. These cases show that the power-down request, the muted flag and the resumed level each follow their own rules.

// File: rtl/fade_pkg.sv
package fade_pkg;

    localparam int unsigned FD_DW = 24;
    localparam int unsigned FD_CW = 14;
    localparam int unsigned FD_PW = FD_DW + FD_CW + 1;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_DOWN = 2'd1,
        DIR_UP   = 2'd2
    } fade_dir_e;

    typedef struct packed {
        logic signed [FD_DW-1:0] l;
        logic signed [FD_DW-1:0] r;
    } fd_pair_t;

    typedef struct packed {
        logic zero_gain;
        logic pin_done;
    } fd_flags_t;

    // S-shaped falling curve: unity at k=0, zero at k=n-1
    function automatic logic [FD_CW-1:0] fd_coef(input int unsigned k, input int unsigned n);
        longint m, den, num, res, kk;
        m   = longint'(n) - 1;
        kk  = longint'(k);
        den = m * m * m;
        num = den - 3 * kk * kk * m + 2 * kk * kk * kk;
        res = ((longint'(1) << (FD_CW - 1)) * num + den / 2) / den;
        return res[FD_CW-1:0];
    endfunction

    // multiply by a Q1.13 gain and round half up
    function automatic logic signed [FD_DW-1:0] fd_scale(input logic signed [FD_DW-1:0] s,
                                                       input logic [FD_CW-1:0] c);
        logic signed [FD_PW-1:0] prod;
        logic signed [FD_PW-1:0] rnd;
        rnd  = FD_PW'(1) <<< (FD_CW - 2);
        prod = FD_PW'(s) * FD_PW'($signed({1'b0, c})) + rnd;
        return prod[FD_CW-1 +: FD_DW];
    endfunction

endpackage

// File: rtl/fade_seq.sv
module fade_seq
    import fade_pkg::*;
#(
    parameter int unsigned NSTEP = 32,
    parameter int unsigned HOLD  = 4,
    localparam int unsigned TOT  = NSTEP * HOLD,
    localparam int unsigned PW   = $clog2(TOT),
    localparam int unsigned IW   = $clog2(NSTEP)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          stb_i,
    input  logic          req_i,
    output logic [IW-1:0] idx_o
);

    localparam logic [PW-1:0] LAST = PW'(TOT - 1);

    logic [PW-1:0] pos;
    fade_dir_e     dir;

    always_comb begin
        if (req_i)
            dir = (pos != LAST) ? DIR_DOWN : DIR_HOLD;
        else
            dir = (pos != '0) ? DIR_UP : DIR_HOLD;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos <= '0;
        end else if (stb_i) begin
            case (dir)
                DIR_DOWN: pos <= pos + PW'(1);
                DIR_UP:   pos <= pos - PW'(1);
                default:  pos <= pos;
            endcase
        end
    end

    assign idx_o = IW'(pos / PW'(HOLD));

endmodule

// File: rtl/fade_gain.sv
module fade_gain
    import fade_pkg::*;
#(
    parameter int unsigned NSTEP = 32,
    localparam int unsigned IW   = $clog2(NSTEP)
) (
    input  logic [IW-1:0]    idx_i,
    output logic [FD_CW-1:0] coef_o,
    output logic             zero_o
);

    logic [FD_CW-1:0] tbl [NSTEP];

    for (genvar g = 0; g < NSTEP; g++) begin : g_tbl
        assign tbl[g] = fd_coef(g, NSTEP);
    end

    assign coef_o = tbl[idx_i];
    assign zero_o = (coef_o == '0);

endmodule

// File: rtl/fade_scale.sv
module fade_scale
    import fade_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             stb_i,
    input  logic             hard_i,
    input  logic             pin_i,
    input  logic [FD_CW-1:0] coef_i,
    input  logic             zero_i,
    input  fd_pair_t         din_i,
    output fd_pair_t         dout_o,
    output fd_flags_t        flags_o
);

    fd_pair_t scaled;

    always_comb begin
        scaled.l = fd_scale(din_i.l, coef_i);
        scaled.r = fd_scale(din_i.r, coef_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dout_o  <= '0;
            flags_o <= '0;
        end else if (stb_i) begin
            dout_o            <= hard_i ? fd_pair_t'('0) : scaled;
            flags_o.zero_gain <= hard_i | zero_i;
            flags_o.pin_done  <= zero_i & pin_i;
        end
    end

endmodule

// File: rtl/cos_fade_mute.sv
module cos_fade_mute
    import fade_pkg::*;
#(
    parameter int unsigned NSTEP = 32,
    parameter int unsigned HOLD  = 4,
    parameter int unsigned NREG  = 2,
    localparam int unsigned IW   = $clog2(NSTEP)
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    smp_stb_i,
    input  logic signed [FD_DW-1:0] smp_l_i,
    input  logic signed [FD_DW-1:0] smp_r_i,
    input  logic                    mute_pin_i,
    input  logic [NREG-1:0]         mute_reg_i,
    input  logic                    hard_mute_i,
    output logic signed [FD_DW-1:0] smp_l_o,
    output logic signed [FD_DW-1:0] smp_r_o,
    output logic                    muted_o,
    output logic                    dac_pd_o
);

    logic             req;
    logic [IW-1:0]    idx;
    logic [FD_CW-1:0] coef;
    logic             zero;
    fd_pair_t         din;
    fd_pair_t         dout;
    fd_flags_t        flags;

    assign req   = mute_pin_i | (|mute_reg_i);
    assign din.l = smp_l_i;
    assign din.r = smp_r_i;

    fade_seq #(.NSTEP(NSTEP), .HOLD(HOLD)) u_seq (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .stb_i (smp_stb_i),
        .req_i (req),
        .idx_o (idx)
    );

    fade_gain #(.NSTEP(NSTEP)) u_gain (
        .idx_i  (idx),
        .coef_o (coef),
        .zero_o (zero)
    );

    fade_scale u_scale (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .stb_i   (smp_stb_i),
        .hard_i  (hard_mute_i),
        .pin_i   (mute_pin_i),
        .coef_i  (coef),
        .zero_i  (zero),
        .din_i   (din),
        .dout_o  (dout),
        .flags_o (flags)
    );

    assign smp_l_o  = dout.l;
    assign smp_r_o  = dout.r;
    assign muted_o  = flags.zero_gain;
    assign dac_pd_o = flags.pin_done;

endmodule

// File: rtl/cos_fade_mute_chk.sv
module cos_fade_mute_chk
    import fade_pkg::*;
#(
    parameter int unsigned NREG = 2
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    smp_stb_i,
    input logic signed [FD_DW-1:0] smp_l_i,
    input logic signed [FD_DW-1:0] smp_r_i,
    input logic                    mute_pin_i,
    input logic [NREG-1:0]         mute_reg_i,
    input logic                    hard_mute_i,
    input logic signed [FD_DW-1:0] smp_l_o,
    input logic signed [FD_DW-1:0] smp_r_o,
    input logic                    muted_o,
    input logic                    dac_pd_o
);

    assert_hard_zero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        smp_stb_i && hard_mute_i |=> (smp_l_o == '0) && (smp_r_o == '0) && muted_o);

    assert_muted_silent_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        muted_o |-> (smp_l_o == '0) && (smp_r_o == '0));

    assert_pd_implies_muted_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        dac_pd_o |-> muted_o);

    assert_pd_from_pin_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(dac_pd_o) |-> $past(mute_pin_i) && $past(smp_stb_i));

    assert_hold_between_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_stb_i |=> $stable(smp_l_o) && $stable(smp_r_o) && $stable(muted_o) && $stable(dac_pd_o));

endmodule

bind cos_fade_mute cos_fade_mute_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/cos_fade_mute_tb.sv
module cos_fade_mute_tb;

    logic               clk = 1'b0;
    logic               rst;
    logic               stb;
    logic signed [23:0] in_l, in_r;
    logic               pin;
    logic [1:0]         rgm;
    logic               hard;
    logic signed [23:0] out_l, out_r;
    logic               muted, pd;

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    int    pos_m = 0;
    string cur   = "R10";

    always #5 clk = ~clk;

    cos_fade_mute u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .smp_stb_i   (stb),
        .smp_l_i     (in_l),
        .smp_r_i     (in_r),
        .mute_pin_i  (pin),
        .mute_reg_i  (rgm),
        .hard_mute_i (hard),
        .smp_l_o     (out_l),
        .smp_r_o     (out_r),
        .muted_o     (muted),
        .dac_pd_o    (pd)
    );

    logic signed [23:0] e_l = '0, e_r = '0;
    logic               e_m = 1'b0, e_pd = 1'b0;

    function automatic int ref_gain(input int k);
        longint num;
        num = 29791 - 93 * longint'(k) * k + 2 * longint'(k) * k * k;
        return int'((8192 * num + 14895) / 29791);
    endfunction

    function automatic logic signed [23:0] ref_mul(input logic signed [23:0] s, input int g);
        longint v;
        v = longint'(s) * g + 4096;
        v = v >>> 13;
        return v[23:0];
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(cur, "left",  out_l, e_l);
        check(cur, "right", out_r, e_r);
        check(cur, "muted", muted, e_m);
        check(cur, "pd",    pd,    e_pd);
    endtask

    // one clock: drive, let the edge pass, update model, compare away from edge
    task automatic tick(input logic s, input logic signed [23:0] l, input logic signed [23:0] r,
                        input logic p, input logic [1:0] rg, input logic h);
        int g;
        stb = s; in_l = l; in_r = r; pin = p; rgm = rg; hard = h;
        @(posedge clk);
        if (s) begin
            g    = ref_gain(pos_m / 4);
            e_l  = h ? 24'sd0 : ref_mul(l, g);
            e_r  = h ? 24'sd0 : ref_mul(r, g);
            e_m  = h || (g == 0);
            e_pd = (g == 0) && p;
            if (p || (rg != 0)) begin
                if (pos_m < 127) pos_m++;
            end else begin
                if (pos_m > 0) pos_m--;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic smp(input logic p, input logic [1:0] rg, input logic h);
        logic signed [23:0] l, r;
        l = 24'($urandom);
        r = 24'($urandom);
        tick(1'b1, l, r, p, rg, h);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(17));
        rst = 1'b1; stb = 0; in_l = 0; in_r = 0; pin = 0; rgm = 0; hard = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        cur = "R10";
        compare_all();
        rst = 1'b0;

        // R6: unity pass-through with extremes, gaps hold output
        cur = "R6";
        tick(1, 24'sh7FFFFF, -24'sh800000, 0, 0, 0);
        tick(1, -24'sd1, 24'sd1, 0, 0, 0);
        repeat (3) tick(0, 24'sd5, 24'sd9, 0, 0, 0);
        repeat (10) smp(0, 0, 0);

        // R2: gain observed directly through a sample of value 8192
        cur = "R2";
        tick(1, 24'sd8192, -24'sd8192, 0, 0, 0);
        check("R2", "unity entry", out_l, 8192);

        // R3 / R8 / R9: pin-driven fade to silence, with gaps
        cur = "R3";
        for (int i = 0; i < 124; i++) begin
            tick(1, 24'sd8192, 24'sd8192, 1, 0, 0);
            if (i % 7 == 3) tick(0, 24'sd0, 24'sd0, 1, 0, 0);
        end
        check("R3", "entry 30 nonzero", (out_l != 0), 1);
        cur = "R9";
        tick(1, 24'sd8192, 24'sd8192, 1, 0, 0);
        check("R2", "final entry zero", out_l, 0);
        check("R8", "muted at floor", muted, 1);
        check("R9", "pd at pin floor", pd, 1);
        repeat (6) smp(1, 0, 0);

        // R7: hard mute while at floor, then while pin keeps fade
        cur = "R7";
        repeat (3) smp(1, 0, 1);

        // R4: release, climb back in reverse
        cur = "R4";
        for (int i = 0; i < 130; i++) smp(0, 0, 0);
        check("R4", "back to unity flag", muted, 0);

        // R1: register bits alone, no power-down request
        cur = "R1";
        for (int i = 0; i < 70; i++) smp(0, 2'b10, 0);
        for (int i = 0; i < 70; i++) smp(0, 2'b01, 0);
        check("R1", "reg fade silent", muted, 1);
        check("R9", "no pd from reg mute", pd, 0);
        for (int i = 0; i < 130; i++) smp(0, 0, 0);

        // R5: reversals at odd positions
        cur = "R5";
        for (int i = 0; i < 37; i++) smp(1, 0, 0);
        for (int i = 0; i < 13; i++) smp(0, 0, 0);
        for (int i = 0; i < 50; i++) smp(0, 2'b11, 0);
        for (int i = 0; i < 9; i++)  smp(0, 0, 0);
        tick(1, 24'sd8192, 24'sd8192, 0, 0, 0);
        check("R5", "mid ramp gain", out_l, ref_gain(pos_m / 4 + ((pos_m % 4 == 3) ? 1 : 0)));

        // R7: hard mute mid ramp keeps ramp position
        cur = "R7";
        for (int i = 0; i < 10; i++) smp(1, 0, 1);
        for (int i = 0; i < 4; i++)  smp(1, 0, 0);
        for (int i = 0; i < 140; i++) smp(0, 0, i % 3 == 0);
        for (int i = 0; i < 5; i++) smp(0, 0, 0);

        // R10: reset mid fade returns to unity
        cur = "R10";
        for (int i = 0; i < 60; i++) smp(1, 0, 0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        pos_m = 0; e_l = 0; e_r = 0; e_m = 0; e_pd = 0;
        compare_all();
        tick(1, 24'sd8192, 24'sd8192, 0, 0, 0);
        check("R10", "unity after reset", out_l, 8192);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule